// File: doc/BRIEF.md
# Wake Pin Interrupt Controller

This controller watches eight always-on wake pins and raises one combined interrupt when any of them sees an event it was told to look for. Each pin can be armed for a falling edge, a rising edge, a low level or a high level. Both edges are armed by enabling the falling and the rising mode for the same pin. Edge modes pass the pin through a two-stage synchronizer. Level modes sample the raw pin directly, so a level event is captured at the first clock edge that sees it.

Every per-pin control vector is reached through three addresses: one that clears the bits written as 1, one that sets them, and one that reads the vector back. Software can therefore change a single pin without a read-modify-write sequence. There are six mode vectors, one per detection mode, plus vectors for detect enable, interrupt enable and pad output enable. A pending vector records captured events and is cleared by writing 1s. The controller also reports the lowest pending, enabled pin as the next pin to service. Reads are combinational on the address and ignore `wr_en`.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset all mode, detect-enable, interrupt-enable, output-enable and pending bits are 0, so `irq` is 0, `svc_idx` is 0 and `pin_oe` is 0.
- R2: Mode vector i (0 to 5) clears the bits written as 1 at address 0x04+12*i, sets them at 0x08+12*i and reads back at 0x0C+12*i; bits written as 0 keep their value. Index 0 is falling edge, 1 low level, 2 high level, 3 rising edge (set address 0x2C), and 4 and 5 are reserved.
- R3: Detect enable uses 0x4C/0x50/0x54 (clear/set/read), interrupt enable uses 0x58/0x5C/0x60 and output enable uses 0x74/0x78/0x7C; `pin_oe` always equals the output-enable vector.
- R4: In a pin's rising or falling mode, a transition on `pin_in` that is in place before clock edge n sets that pin's pending bit at edge n+2 (two synchronizer stages).
- R5: With both the falling and the rising mode set for a pin, each transition in either direction sets its pending bit.
- R6: In the low or high level mode, the pending bit is set at every clock edge at which the raw pin is at that level, with no synchronizer delay.
- R7: Reserved modes 4 and 5 store their bits but never set a pending bit.
- R8: No event sets a pending bit while that pin's detect-enable bit is 0.
- R9: Pending reads at 0x64, and writing 1s there clears those bits; if an event fires for the same pin in the same cycle, the bit stays set.
- R10: `irq` is the OR of (pending AND interrupt enable); interrupt enable does not gate the capture into pending.
- R11: `svc_idx` is the index of the lowest set bit of (pending AND interrupt enable), and is 0 when none is set.
- R12: Unmapped addresses, and all clear and set addresses, read as 0; writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Wake pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data, one bit per pin |
| rdata | output | 8 | Combinational read data for `addr` |
| pin_oe | output | 8 | Pad output enable per pin |
| irq | output | 1 | Combined interrupt |
| svc_idx | output | 3 | Lowest pending, enabled pin |

## Verification
The bench targets the edge-to-pending latency. A synchronizer that is one stage short or long would capture events a cycle early or late. An edge detector with swapped polarity would flag the wrong direction when only one edge mode is set. Several tests clear pending while a level is still held; a design that let the clear win would drop a pin that is still asserting. The bench also checks reserved modes 4 and 5, pins with detect disabled, and interrupt enable being removed while events are pending. A mistaken decode would then show up as phantom pending bits or as pending bits that were lost. Multi-pin pending sets with different enable masks expose a priority encoder that picks the highest bit instead of the lowest.

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl #(
  parameter int NPIN  = 8,
  parameter int AW    = 8,
  parameter int NMODE = 6,
  parameter int SYNC  = 2,
  parameter int IW    = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq,
  output logic [IW-1:0]   svc_idx
);

  localparam int M_FALL = 0;
  localparam int M_LOW  = 1;
  localparam int M_HIGH = 2;
  localparam int M_RISE = 3;

  localparam int MODE_BASE   = 'h04;
  localparam int MODE_STRIDE = 12;
  localparam int DET_BASE    = 'h4C;
  localparam int IEN_BASE    = 'h58;
  localparam int PEND_ADDR   = 'h64;
  localparam int OE_BASE     = 'h74;

  logic [NMODE-1:0][NPIN-1:0] mode_q;
  logic [NPIN-1:0] det_q, ien_q, oe_q, pend_q;
  logic [SYNC:0][NPIN-1:0] sync_q;
  logic [NPIN-1:0] rise, fall, fire, clr, act;

  function automatic logic [NPIN-1:0] tri_upd(input logic [NPIN-1:0] cur, input int base);
    logic [NPIN-1:0] nx;
    nx = cur;
    if (wr_en && addr == AW'(base))     nx = cur & ~wdata;
    if (wr_en && addr == AW'(base + 4)) nx = cur | wdata;
    return nx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      det_q  <= '0;
      ien_q  <= '0;
      oe_q   <= '0;
    end else begin
      for (int i = 0; i < NMODE; i++)
        mode_q[i] <= tri_upd(mode_q[i], MODE_BASE + MODE_STRIDE * i);
      det_q <= tri_upd(det_q, DET_BASE);
      ien_q <= tri_upd(ien_q, IEN_BASE);
      oe_q  <= tri_upd(oe_q, OE_BASE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k <= SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~sync_q[SYNC];
  assign fall = ~sync_q[SYNC-1] & sync_q[SYNC];
  assign fire = det_q & ((mode_q[M_FALL] & fall) | (mode_q[M_RISE] & rise) |
                         (mode_q[M_LOW] & ~pin_in) | (mode_q[M_HIGH] & pin_in));
  assign clr  = (wr_en && addr == AW'(PEND_ADDR)) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | fire;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NMODE; i++)
      if (addr == AW'(MODE_BASE + MODE_STRIDE * i + 8)) rdata = mode_q[i];
    if (addr == AW'(DET_BASE + 8))  rdata = det_q;
    if (addr == AW'(IEN_BASE + 8))  rdata = ien_q;
    if (addr == AW'(OE_BASE + 8))   rdata = oe_q;
    if (addr == AW'(PEND_ADDR))     rdata = pend_q;
  end

  assign act    = pend_q & ien_q;
  assign irq    = |act;
  assign pin_oe = oe_q;

  always_comb begin
    svc_idx = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (act[i]) svc_idx = IW'(i);
  end

  // R8
  no_det_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(det_q)) == '0));

  // R7
  reserved_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) &
               ~$past(mode_q[M_FALL] | mode_q[M_LOW] | mode_q[M_HIGH] | mode_q[M_RISE])) == '0));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(PEND_ADDR)) |=> ((pend_q & $past(wdata) & ~$past(fire)) == '0));

  // R11
  svc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q[svc_idx] && ien_q[svc_idx] &&
             ((pend_q & ien_q & ((NPIN'(1) << svc_idx) - NPIN'(1))) == '0)));

  // R3
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == AW'(OE_BASE) || addr == AW'(OE_BASE + 4))) |=> $stable(pin_oe));

endmodule

// File: tb/wake_irq_ctrl_bench.sv
module wake_irq_ctrl_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] pin_in = 0, addr = 0, wdata = 0, rdata, pin_oe;
  logic irq;
  logic [2:0] svc_idx;

  wake_irq_ctrl u_wake_irq_ctrl (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe), .irq(irq), .svc_idx(svc_idx));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [7:0] m_mode [6];
  logic [7:0] m_det = 0, m_ien = 0, m_oe = 0, m_pend = 0, pins = 0;
  logic [7:0] hq [$];

  function automatic logic [7:0] m_read(input logic [7:0] a);
    for (int i = 0; i < 6; i++) if (a == 8'(12 + 12 * i)) return m_mode[i];
    case (a)
      8'h54: return m_det;
      8'h60: return m_ien;
      8'h64: return m_pend;
      8'h7C: return m_oe;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check1(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int low;
    low = 0;
    for (int i = 7; i >= 0; i--) if (m_pend[i] & m_ien[i]) low = i;
    check1({tag, " rdata"}, rdata, m_read(addr));
    check1("R10 irq", irq, |(m_pend & m_ien));
    check1("R11 svc_idx", svc_idx, low);
    check1("R3 pin_oe", pin_oe, m_oe);
  endtask

  task automatic step(input string tag, input logic we, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] p0, p2, p3, rise, fall, fire, clr;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; pin_in = pins;
    p0 = pins; p2 = hq[$-1]; p3 = hq[$-2];
    rise = p2 & ~p3;
    fall = ~p2 & p3;
    fire = m_det & ((m_mode[0] & fall) | (m_mode[3] & rise) | (m_mode[1] & ~p0) | (m_mode[2] & p0));
    clr = (we && a == 8'h64) ? d : 8'h00;
    m_pend = (m_pend & ~clr) | fire;
    if (we) begin
      for (int i = 0; i < 6; i++) begin
        if (a == 8'(4 + 12 * i)) m_mode[i] = m_mode[i] & ~d;
        if (a == 8'(8 + 12 * i)) m_mode[i] = m_mode[i] | d;
      end
      case (a)
        8'h4C: m_det = m_det & ~d;
        8'h50: m_det = m_det | d;
        8'h58: m_ien = m_ien & ~d;
        8'h5C: m_ien = m_ien | d;
        8'h74: m_oe = m_oe & ~d;
        8'h78: m_oe = m_oe | d;
        default: ;
      endcase
    end
    hq.push_back(p0);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    step(tag, 1'b1, a, d);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, 1'b0, a, 8'h00);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h64, 8'h00);
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_mode[i] = 0;
    hq.push_back(8'h00); hq.push_back(8'h00); hq.push_back(8'h00);
    addr = 8'h64;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1;
    rd("R1", 8'h0C); rd("R1", 8'h54); rd("R1", 8'h60); rd("R1", 8'h7C); rd("R1", 8'h64);

    wr("R2", 8'h08, 8'hA5); rd("R2", 8'h0C);
    wr("R2", 8'h04, 8'h05); rd("R2", 8'h0C);
    wr("R2", 8'h44, 8'hFF); rd("R2", 8'h48);
    wr("R2", 8'h40, 8'h0F); rd("R2", 8'h48);
    wr("R2", 8'h20, 8'h11); rd("R2", 8'h24); rd("R2", 8'h18); rd("R2", 8'h30); rd("R2", 8'h3C);
    wr("R2", 8'h04, 8'hFF); wr("R2", 8'h40, 8'hFF); wr("R2", 8'h1C, 8'hFF);

    wr("R3", 8'h50, 8'h3C); rd("R3", 8'h54);
    wr("R3", 8'h4C, 8'h0C); rd("R3", 8'h54);
    wr("R3", 8'h5C, 8'h81); rd("R3", 8'h60);
    wr("R3", 8'h78, 8'hF0); rd("R3", 8'h7C);
    wr("R3", 8'h74, 8'h30); rd("R3", 8'h7C);
    wr("R3", 8'h4C, 8'hFF); wr("R3", 8'h58, 8'hFF);

    wr("R12", 8'h68, 8'hFF); rd("R12", 8'h68); rd("R12", 8'h00); rd("R12", 8'h08);
    rd("R12", 8'h50); rd("R12", 8'h70); rd("R12", 8'h80); rd("R12", 8'hFF);
    wr("R12", 8'h00, 8'hFF); rd("R12", 8'h7C); rd("R12", 8'h64);

    wr("R4", 8'h2C, 8'h01); wr("R4", 8'h50, 8'h01); wr("R4", 8'h5C, 8'h01);
    idle("R4", 3);
    pins[0] = 1; idle("R4 rise", 5);
    wr("R4", 8'h64, 8'h01); idle("R4", 2);
    pins[0] = 0; idle("R4 fall ignored", 4);
    wr("R4", 8'h08, 8'h02); wr("R4", 8'h50, 8'h02); wr("R4", 8'h5C, 8'h02);
    pins[1] = 1; idle("R4 rise ignored", 4);
    pins[1] = 0; idle("R4 fall", 4);
    wr("R4", 8'h64, 8'h03); idle("R4", 2);

    wr("R5", 8'h08, 8'h04); wr("R5", 8'h2C, 8'h04);
    wr("R5", 8'h50, 8'h04); wr("R5", 8'h5C, 8'h04);
    pins[2] = 1; idle("R5 rise", 4);
    wr("R5", 8'h64, 8'h04); idle("R5", 1);
    pins[2] = 0; idle("R5 fall", 4);
    wr("R5", 8'h64, 8'h04);
    pins[2] = 1; step("R5 short pulse", 1'b0, 8'h64, 8'h00);
    pins[2] = 0; idle("R5 short pulse", 5);
    wr("R5", 8'h64, 8'h04);

    wr("R6", 8'h14, 8'h08); wr("R6", 8'h20, 8'h10);
    wr("R6", 8'h5C, 8'h18); wr("R6", 8'h50, 8'h18);
    idle("R6 low", 3);
    pins[3] = 1; pins[4] = 1; idle("R6 high", 2);
    wr("R9", 8'h64, 8'hFF); idle("R9 held level", 2);
    pins[4] = 0; wr("R9", 8'h64, 8'hFF); idle("R9 cleared", 3);

    wr("R7", 8'h38, 8'h20); wr("R7", 8'h44, 8'h20);
    wr("R7", 8'h50, 8'h20); wr("R7", 8'h5C, 8'h20);
    pins[5] = 1; idle("R7", 4); pins[5] = 0; idle("R7", 4);
    rd("R7", 8'h3C); rd("R7", 8'h48);

    wr("R8", 8'h20, 8'h40); wr("R8", 8'h5C, 8'h40);
    pins[6] = 1; idle("R8 no detect", 4);
    wr("R8", 8'h50, 8'h40); idle("R8 detect", 2);
    wr("R8", 8'h4C, 8'h40); wr("R8", 8'h64, 8'h40); idle("R8 disabled", 3);

    wr("R10", 8'h58, 8'hFF); wr("R10", 8'h50, 8'h50);
    pins[4] = 1; idle("R10 masked capture", 3);
    rd("R10", 8'h64);
    wr("R11", 8'h5C, 8'h40); idle("R11", 1);
    wr("R11", 8'h5C, 8'h10); idle("R11", 1);
    wr("R11", 8'h58, 8'h10); idle("R11", 1);
    wr("R11", 8'h5C, 8'h01); pins[0] = 0; pins[0] = 1; idle("R11", 4);
    wr("R10", 8'h58, 8'hFF); rd("R10", 8'h64);
    wr("R10", 8'h4C, 8'hFF); wr("R10", 8'h64, 8'hFF); idle("R10", 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule